// File: doc/BRIEF.md
# Write-Through Store Queue

This block sits between a write-through, no-write-allocate cache and main memory. Every processor store, hit or miss, is written into a small FIFO and retires at once. The FIFO then drains queued word writes to memory in the background, one write per memory handshake, so the processor does not stall on memory for stores. A store that missed the cache does not allocate a line. It goes through this queue as a plain word write.

Reads that missed the cache are presented to this block rather than directly to memory. Each read address is compared against every queued store. If at least one entry matches, the data of the youngest matching entry is returned one cycle later and memory is not touched. If nothing matches, the block pauses draining and issues a memory read, then returns the memory data. No older store to that address can still be queued, so memory already holds the current value.

The controller is a three-state machine. In `RS_IDLE` it accepts reads and drains the queue. Its transition `idle_to_issue` is taken on an accepted read with no match. In `RS_ISSUE` it holds a memory read request, and `issue_to_wait` is taken on the memory grant. In `RS_WAIT` it waits for read data, and `wait_to_idle` is taken when memory returns that data.

Top module: `wt_store_buffer`

## Requirements
- R1: `st_ready` is high exactly when fewer than DEPTH stores are queued. A store is accepted on a cycle with `st_valid` and `st_ready` both high.
- R2: Queued stores reach memory strictly in acceptance order. Each one is a single write handshake (`mem_req`, `mem_we` and `mem_gnt` all high). When the queue is empty in `RS_IDLE`, no request is made.
- R3: A store may be accepted in the same cycle as a drain handshake, and both take effect.
- R4: A read accepted while one or more queued stores hold its address gets `rd_resp_valid` in the next cycle, with the data of the most recently accepted matching store.
- R5: A read with no match issues a memory read (`mem_we` low) with the read address. The request is held until `mem_gnt`, and the response carries `mem_rdata` in the cycle after `mem_rvalid`.
- R6: `rd_ready` is low from the cycle after a non-matching read is accepted until memory data returns. No drain write is requested in that time.
- R7: A store accepted in the same cycle as a read counts as younger than that read and is not visible to it.
- R8: After reset the queue is empty, `st_ready` and `rd_ready` are high, and `mem_req` and `rd_resp_valid` are low.
- R9: Under any mix of stores and reads, every read returns the value of the latest store to that address accepted before it, or the initial memory contents if there was none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Queue can take a store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| rd_valid | input | 1 | Read request (cache miss) |
| rd_ready | output | 1 | Read can be accepted |
| rd_addr | input | AW | Read word address |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_data | output | DW | Read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write (drain), 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench fills the queue with memory grants withheld, so the full stall and several stores to one address are seen. A design that forwarded the oldest match would return the first of those values, and a design that let a store in while full would overwrite the oldest entry. A non-matching read is issued while writes are still blocked, so a design that kept draining during the read, or returned data early, would give a wrong value or an out-of-order write. A store and a read to the same address in one cycle check that the read does not see the younger store. A long random run with a small address space and random grants compares every read and every drained write against a behavioural memory.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_ISSUE = 2'd1,
        RS_WAIT  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/wsb_fifo.sv
// Store queue storage. Pointers carry one extra wrap bit. DEPTH must be a power of two, at least 2.
module wsb_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [AW-1:0]                 push_addr,
    input  logic [DW-1:0]                 push_data,
    input  logic                          pop,
    output logic                          full,
    output logic                          empty,
    output logic [AW-1:0]                 head_addr,
    output logic [DW-1:0]                 head_data,
    output logic [PW-1:0]                 rd_idx,
    output logic [PW:0]                   fill,
    output logic [DEPTH-1:0][AW-1:0]      ent_addr,
    output logic [DEPTH-1:0][DW-1:0]      ent_data
);
    logic [PW:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            ent_addr[wptr[PW-1:0]] <= push_addr;
            ent_data[wptr[PW-1:0]] <= push_data;
        end
    end

    always_comb begin
        empty     = (wptr == rptr);
        full      = (wptr[PW] != rptr[PW]) && (wptr[PW-1:0] == rptr[PW-1:0]);
        fill      = wptr - rptr;
        rd_idx    = rptr[PW-1:0];
        head_addr = ent_addr[rptr[PW-1:0]];
        head_data = ent_data[rptr[PW-1:0]];
    end
endmodule

// File: rtl/wsb_match.sv
// Searches valid entries from oldest to youngest; a later hit overrides an earlier one.
module wsb_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0][DW-1:0] ent_data,
    input  logic [PW-1:0]            rd_idx,
    input  logic [PW:0]              fill,
    input  logic [AW-1:0]            look_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);
    logic [PW-1:0] idx;

    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        idx      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = rd_idx + PW'(i);
            if ((PW+1)'(i) < fill) begin
                if (ent_addr[idx] == look_addr) begin
                    hit      = 1'b1;
                    hit_data = ent_data[idx];
                end
            end
        end
    end
endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer
    import wsb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_resp_valid,
    output logic [DW-1:0] rd_resp_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    localparam int PW = $clog2(DEPTH);

    rd_state_e state, state_nx;

    logic                     q_full, q_empty, q_push, q_pop;
    logic [AW-1:0]            q_head_addr;
    logic [DW-1:0]            q_head_data;
    logic [PW-1:0]            q_rd_idx;
    logic [PW:0]              q_fill;
    logic [DEPTH-1:0][AW-1:0] q_ent_addr;
    logic [DEPTH-1:0][DW-1:0] q_ent_data;
    logic                     look_hit;
    logic [DW-1:0]            look_data;
    logic                     rd_go;
    logic [AW-1:0]            miss_addr;

    assign q_push = st_valid && st_ready;
    assign rd_go  = rd_valid && rd_ready;

    wsb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (q_pop),
        .full      (q_full),
        .empty     (q_empty),
        .head_addr (q_head_addr),
        .head_data (q_head_data),
        .rd_idx    (q_rd_idx),
        .fill      (q_fill),
        .ent_addr  (q_ent_addr),
        .ent_data  (q_ent_data)
    );

    wsb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .ent_addr  (q_ent_addr),
        .ent_data  (q_ent_data),
        .rd_idx    (q_rd_idx),
        .fill      (q_fill),
        .look_addr (rd_addr),
        .hit       (look_hit),
        .hit_data  (look_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    // Transitions: idle_to_issue, issue_to_wait, wait_to_idle
    always_comb begin
        state_nx = state;
        unique case (state)
            RS_IDLE:  if (rd_go && !look_hit) state_nx = RS_ISSUE;
            RS_ISSUE: if (mem_gnt)            state_nx = RS_WAIT;
            RS_WAIT:  if (mem_rvalid)         state_nx = RS_IDLE;
            default:                          state_nx = RS_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        st_ready  = !q_full;
        rd_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q_head_addr;
        mem_wdata = q_head_data;
        q_pop     = 1'b0;
        unique case (state)
            RS_IDLE: begin
                rd_ready = 1'b1;
                mem_req  = !q_empty;
                mem_we   = 1'b1;
                q_pop    = !q_empty && mem_gnt;
            end
            RS_ISSUE: begin
                mem_req  = 1'b1;
                mem_addr = miss_addr;
            end
            RS_WAIT: begin
                mem_addr = miss_addr;
            end
            default: ;
        endcase
    end

    // Registered read response and captured miss address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_resp_valid <= 1'b0;
            rd_resp_data  <= '0;
            miss_addr     <= '0;
        end else begin
            rd_resp_valid <= 1'b0;
            if (rd_go) begin
                miss_addr <= rd_addr;
                if (look_hit) begin
                    rd_resp_valid <= 1'b1;
                    rd_resp_data  <= look_data;
                end
            end
            if (state == RS_WAIT && mem_rvalid) begin
                rd_resp_valid <= 1'b1;
                rd_resp_data  <= mem_rdata;
            end
        end
    end
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic          look_hit,
    input logic          rd_resp_valid,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic          mem_rvalid,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata
);
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready && look_hit |=> rd_resp_valid); // R4

    AST_NO_DRAIN_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ready |-> !(mem_req && mem_we)); // R6

    AST_READ_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && !mem_gnt |=> mem_req && !mem_we && $stable(mem_addr)); // R5

    AST_WRITE_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !mem_gnt && !(rd_valid && rd_ready)
        |=> mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata)); // R2

    AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_resp_valid |-> $past(rd_valid && rd_ready) || $past(mem_rvalid)); // R9
endmodule

bind wt_store_buffer wsb_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .look_hit      (look_hit),
    .rd_resp_valid (rd_resp_valid),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_gnt       (mem_gnt),
    .mem_rvalid    (mem_rvalid),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata)
);

// File: tb/wt_store_buffer_test.sv
module wt_store_buffer_test;
    localparam int DEPTH = 4;
    localparam int AW    = 8;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          rd_valid = 1'b0;
    logic          rd_ready;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_resp_valid;
    logic [DW-1:0] rd_resp_data;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_gnt = 1'b0;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    wt_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (.*);

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit wr_gnt_en = 1'b0;
    bit rv_flag = 1'b0;
    logic [DW-1:0] rv_data = '0;
    logic [DW-1:0] arch_mem [0:(1<<AW)-1];
    logic [DW-1:0] phys_mem [0:(1<<AW)-1];
    logic [AW+DW-1:0] pend [$];
    logic [DW-1:0] exp_rd [$];

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) begin
            arch_mem[i] = '0;
            phys_mem[i] = '0;
        end
    end

    // Memory model and reference checker, evaluated at each falling edge
    always @(negedge clk) begin
        mem_rvalid = rv_flag;
        mem_rdata  = rv_data;
        rv_flag    = 1'b0;
        if (mem_we) mem_gnt = wr_gnt_en && ($urandom % 2 == 0);
        else        mem_gnt = ($urandom % 3 != 0);
        #2;
        if (rst_n) begin
            cycles++;
            if (cycles > 150000) begin
                check(1'b0, "watchdog", 0, 1);
                finish_run();
            end
            // R1: ready tracks queue occupancy
            check(st_ready == (pend.size() < DEPTH), "R1", st_ready, pend.size() < DEPTH);
            // R2: no request when idle and empty
            if (rd_ready && pend.size() == 0)
                check(!mem_req, "R2", mem_req, 0);
            // R6: no drain while a memory read is in progress
            if (!rd_ready)
                check(!(mem_req && mem_we), "R6", mem_req && mem_we, 0);
            // R9 response check
            if (rd_resp_valid) begin
                if (exp_rd.size() == 0) check(1'b0, "R9", rd_resp_data, 'x);
                else begin
                    logic [DW-1:0] e;
                    e = exp_rd.pop_front();
                    check(rd_resp_data == e, "R9", rd_resp_data, e);
                end
            end
            // R7: read sees the state before a same-cycle store
            if (rd_valid && rd_ready) exp_rd.push_back(arch_mem[rd_addr]);
            // R2/R3: drain order, store may coincide
            if (mem_req && mem_we && mem_gnt) begin
                if (pend.size() == 0) check(1'b0, "R2", mem_addr, 'x);
                else begin
                    logic [AW+DW-1:0] f;
                    f = pend.pop_front();
                    check({mem_addr, mem_wdata} == f, "R2", {mem_addr, mem_wdata}, f);
                    phys_mem[mem_addr] = mem_wdata;
                end
            end
            if (st_valid && st_ready) begin
                pend.push_back({st_addr, st_data});
                arch_mem[st_addr] = st_data;
            end
            // R5: read request goes out with data returned next cycle
            if (mem_req && !mem_we && mem_gnt) begin
                rv_flag = 1'b1;
                rv_data = phys_mem[mem_addr];
            end
        end
    end

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        rd_valid = 1'b1; rd_addr = a;
        #1;
        while (!rd_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R8: reset state
        check(st_ready && rd_ready, "R8", {st_ready, rd_ready}, 2'b11);
        check(!mem_req && !rd_resp_valid, "R8", {mem_req, rd_resp_valid}, 0);
        @(negedge clk);

        // Fill with writes blocked; several stores to address 1
        do_store(8'd1, 32'h11);
        do_store(8'd1, 32'h22);
        do_store(8'd2, 32'h33);
        do_store(8'd1, 32'h44);
        #1;
        check(!st_ready, "R1", st_ready, 0); // full stall
        @(negedge clk);
        // R4: newest of three matches
        do_read(8'd1);
        #4;
        check(rd_resp_valid && rd_resp_data == 32'h44, "R4", rd_resp_data, 32'h44);
        @(negedge clk);
        // R5: miss goes to memory while writes remain blocked
        do_read(8'd5);
        #1;
        check(!rd_ready, "R6", rd_ready, 0);
        repeat (20) @(negedge clk);
        check(pend.size() == DEPTH, "R6", pend.size(), DEPTH);

        wr_gnt_en = 1'b1;
        repeat (30) @(negedge clk);
        check(pend.size() == 0, "R2", pend.size(), 0);

        // R7: store and read to the same address in one cycle
        st_valid = 1'b1; st_addr = 8'd6; st_data = 32'h55;
        rd_valid = 1'b1; rd_addr = 8'd6;
        @(negedge clk);
        st_valid = 1'b0; rd_valid = 1'b0;
        // R4 again: the store is now visible
        do_read(8'd6);
        #4;
        check(rd_resp_valid && rd_resp_data == 32'h55, "R7", rd_resp_data, 32'h55);
        @(negedge clk);

        // R3/R9: random mix of stores and reads
        for (int c = 0; c < 4000; c++) begin
            st_valid = ($urandom % 3 == 0);
            st_addr  = AW'($urandom % 8);
            st_data  = $urandom;
            rd_valid = rd_ready && ($urandom % 4 == 0);
            rd_addr  = AW'($urandom % 8);
            @(negedge clk);
        end
        st_valid = 1'b0; rd_valid = 1'b0;
        repeat (60) @(negedge clk);
        check(pend.size() == 0 && exp_rd.size() == 0, "R9", pend.size() + exp_rd.size(), 0);
        finish_run();
    end
endmodule